// File: doc/BRIEF.md
# Firmware Hub Register Decoder with Strap-ID Selection

This block sits behind the bus front end of a memory-mapped flash device that shares one bus with several identical parts. Each part is told its position on the bus by four strap pins. Every bus cycle carries an ID field. The decoder compares that field with the strap value and takes part in the cycle only when the two are equal. On a mismatch it ignores the rest of the cycle and stays idle.

When the part is selected, it serves a small register window. A general-purpose input register returns the live levels of five input pins. A row of per-block lock registers can be read and written, and each one drives a write-inhibit line to the array. The window sits at fixed addresses for the boot part, which is strapped to ID 0. Parts with a higher ID see the same window moved down by ID × `PAGE_SIZE`. While the array reports an internal program or erase, every register access is dropped.

Read data, the selected flag and the lock lines are all registered. Read data appears on the clock edge that samples the read strobe, and it is 00h in every cycle that did not carry a valid read.

Top module: `fwh_reg_decode`

## Requirements
- R1: `selected` is 1 in the cycle after an edge where `rd_en` or `wr_en` was high with `cyc_id` equal to `strap_id`, and 0 otherwise.
- R2: A cycle whose `cyc_id` differs from `strap_id` returns `rd_data` = 00h and leaves every lock bit unchanged.
- R3: For strap value n, the input register sits at 32'hFFBC_0100 − n × 32'h0040_0000. A read of it returns {3'b000, `gpi_pins`} as sampled at the read edge, so bits 7:5 are 0.
- R4: For strap value n, the lock register of block k sits at 32'hFFB0_0002 + k × 32'h0001_0000 − n × 32'h0040_0000. A read of it returns {7'b0, lock bit k}.
- R5: A write to lock register k sets lock bit k to `wr_data[0]`. Bits 7:1 are discarded, all other lock bits are unchanged, and the new value appears on `lock_bits[k]` after that edge.
- R6: After reset all lock bits are 1 (locked), `rd_data` is 00h and `selected` is 0.
- R7: A read of any address that is not in the register window returns 00h. A write to such an address, or to the input register, changes no lock bit.
- R8: While `array_busy` is high, a read returns 00h and a write changes no lock bit. `selected` still follows R1.
- R9: `rd_data` is 00h in every cycle after an edge that carried no valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_id | input | 4 | Strapped device position on the bus |
| cyc_id | input | 4 | ID field of the current bus cycle |
| addr | input | 32 | Cycle address |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| gpi_pins | input | 5 | General-purpose input pin levels |
| array_busy | input | 1 | Internal program or erase in progress |
| rd_data | output | 8 | Registered read data |
| selected | output | 1 | Registered ID-match flag for the last strobed cycle |
| lock_bits | output | 16 | Per-block write-inhibit lines, 1 = locked |

## Verification
Reads of the input register are repeated with different pin patterns. This tells a true pass-through apart from a value held from an earlier read, and it shows that the reserved bits stay at 0. Lock writes use data bytes whose upper bits differ from bit 0, and they target the first block, the last block and a middle block, so that a wrong index or a wrong data bit shows up on `lock_bits`. The same accesses are then repeated with a mismatched cycle ID, with the busy flag raised, and at addresses just outside the window. Each of these must look exactly like no access at all. Strap values 0, 2 and 15 move the window, which separates correct base offsetting from a decoder that is fixed at boot addresses.

// File: rtl/fwh_reg_pkg.sv
package fwh_reg_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned GPI_W  = 5;
  localparam int unsigned BLOCKS = 16;

  localparam logic [ADDR_W-1:0] GPI_BOOT_ADDR  = 32'hFFBC_0100;
  localparam logic [ADDR_W-1:0] LOCK_BOOT_BASE = 32'hFFB0_0002;
  localparam logic [ADDR_W-1:0] LOCK_STRIDE    = 32'h0001_0000;
  localparam logic [ADDR_W-1:0] ID_PAGE_SIZE   = 32'h0040_0000;
endpackage

// File: rtl/fwh_id_match.sv
module fwh_id_match #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] strap_id,
  input  logic [ID_W-1:0] cyc_id,
  input  logic            rd_en,
  input  logic            wr_en,
  output logic            id_ok,
  output logic            sel_q
);
  assign id_ok = (cyc_id == strap_id);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= id_ok && (rd_en || wr_en);
  end

  // R1: a raised select flag traces back to a strobed cycle with matching ID
  p_sel_source_r1: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> $past((cyc_id == strap_id) && (rd_en || wr_en)));
  // R2: a mismatched cycle never raises the flag
  p_mismatch_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_id != strap_id) |=> !sel_q);
endmodule

// File: rtl/fwh_addr_decode.sv
module fwh_addr_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned BLOCKS = 16,
  parameter logic [ADDR_W-1:0] GPI_BOOT_ADDR  = 32'hFFBC_0100,
  parameter logic [ADDR_W-1:0] LOCK_BOOT_BASE = 32'hFFB0_0002,
  parameter logic [ADDR_W-1:0] LOCK_STRIDE    = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] ID_PAGE_SIZE   = 32'h0040_0000
) (
  input  logic [ID_W-1:0]   strap_id,
  input  logic [ADDR_W-1:0] addr,
  output logic              gpi_hit,
  output logic [BLOCKS-1:0] lock_hit
);
  logic [ADDR_W-1:0] page_off;

  assign page_off = ADDR_W'(strap_id) * ID_PAGE_SIZE;
  assign gpi_hit  = (addr == (GPI_BOOT_ADDR - page_off));

  for (genvar k = 0; k < BLOCKS; k++) begin : g_lock_dec
    localparam logic [ADDR_W-1:0] BOOT_ADDR = LOCK_BOOT_BASE + ADDR_W'(k) * LOCK_STRIDE;
    assign lock_hit[k] = (addr == (BOOT_ADDR - page_off));
  end
endmodule

// File: rtl/fwh_lock_regs.sv
module fwh_lock_regs #(
  parameter int unsigned BLOCKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [BLOCKS-1:0] lock_hit,
  input  logic              wr_bit,
  output logic [BLOCKS-1:0] lock_q
);
  for (genvar k = 0; k < BLOCKS; k++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)                     lock_q[k] <= 1'b1;
      else if (wr_go && lock_hit[k]) lock_q[k] <= wr_bit;
    end

    // R5: an accepted write to block k lands in bit k
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_go && lock_hit[k]) |=> (lock_q[k] == $past(wr_bit)));
    // R5/R7: without a write to block k its bit holds
    p_bit_holds_r7: assert property (@(posedge clk) disable iff (rst)
      !(wr_go && lock_hit[k]) |=> $stable(lock_q[k]));
  end

  // R6: reset leaves every block locked
  p_reset_locked_r6: assert property (@(posedge clk) rst |=> (&lock_q));
endmodule

// File: rtl/fwh_reg_decode.sv
module fwh_reg_decode
  import fwh_reg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned IW = ID_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned GW = GPI_W,
  parameter int unsigned NB = BLOCKS,
  parameter logic [ADDR_W-1:0] PAGE_SIZE = ID_PAGE_SIZE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] strap_id,
  input  logic [IW-1:0] cyc_id,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [GW-1:0] gpi_pins,
  input  logic          array_busy,
  output logic [DW-1:0] rd_data,
  output logic          selected,
  output logic [NB-1:0] lock_bits
);
  logic          id_ok;
  logic          gpi_hit;
  logic [NB-1:0] lock_hit;
  logic          rd_go;
  logic          wr_go;
  logic [DW-1:0] rd_next;
  logic          unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DW-1:1];

  fwh_id_match #(.ID_W(IW)) u_match (
    .clk(clk), .rst(rst), .strap_id(strap_id), .cyc_id(cyc_id),
    .rd_en(rd_en), .wr_en(wr_en), .id_ok(id_ok), .sel_q(selected)
  );

  fwh_addr_decode #(
    .ADDR_W(AW), .ID_W(IW), .BLOCKS(NB),
    .GPI_BOOT_ADDR(GPI_BOOT_ADDR), .LOCK_BOOT_BASE(LOCK_BOOT_BASE),
    .LOCK_STRIDE(LOCK_STRIDE), .ID_PAGE_SIZE(PAGE_SIZE)
  ) u_dec (
    .strap_id(strap_id), .addr(addr), .gpi_hit(gpi_hit), .lock_hit(lock_hit)
  );

  assign rd_go = rd_en && id_ok && !array_busy;
  assign wr_go = wr_en && id_ok && !array_busy;

  fwh_lock_regs #(.BLOCKS(NB)) u_locks (
    .clk(clk), .rst(rst), .wr_go(wr_go), .lock_hit(lock_hit),
    .wr_bit(wr_data[0]), .lock_q(lock_bits)
  );

  always_comb begin
    rd_next = '0;
    if (rd_go) begin
      if (gpi_hit) rd_next = DW'(gpi_pins);
      for (int k = 0; k < int'(NB); k++) begin
        if (lock_hit[k]) rd_next = DW'(lock_bits[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R8: reads during a busy array return zero
  p_busy_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    array_busy |=> (rd_data == '0));
  // R8: writes during a busy array leave the lock lines alone
  p_busy_write_hold_r8: assert property (@(posedge clk) disable iff (rst)
    array_busy |=> $stable(lock_bits));
  // R9: no valid read, no data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
  // R3: reserved input bits never set
  p_gpi_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && gpi_hit) |-> (rd_data[DW-1:GW] == '0));
  // R2: a mismatched cycle returns nothing
  p_mismatch_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_id != strap_id) |=> (rd_data == '0));
endmodule

// File: tb/fwh_reg_decode_test.sv
module fwh_reg_decode_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  strap_id, cyc_id;
  logic [31:0] addr;
  logic        rd_en, wr_en, array_busy;
  logic [7:0]  wr_data;
  logic [4:0]  gpi_pins;
  logic [7:0]  rd_data;
  logic        selected;
  logic [15:0] lock_bits;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fwh_reg_decode uut (
    .clk(clk), .rst(rst), .strap_id(strap_id), .cyc_id(cyc_id), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .gpi_pins(gpi_pins),
    .array_busy(array_busy), .rd_data(rd_data), .selected(selected),
    .lock_bits(lock_bits)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  strap;
    logic [3:0]  cyc;
    logic [31:0] a;
    logic        rd;
    logic        wr;
    logic [7:0]  wd;
    logic [4:0]  gpi;
    logic        busy;
    logic [7:0]  exp_rd;
    logic        exp_sel;
    logic [15:0] exp_lock;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    // R3: boot input register, two pin patterns
    '{4'd3, 4'h0, 4'h0, 32'hFFBC_0100, 1'b1, 1'b0, 8'h00, 5'h15, 1'b0, 8'h15, 1'b1, 16'hFFFF},
    '{4'd3, 4'h0, 4'h0, 32'hFFBC_0100, 1'b1, 1'b0, 8'h00, 5'h1F, 1'b0, 8'h1F, 1'b1, 16'hFFFF},
    // R5: unlock block 3, upper data bits set
    '{4'd5, 4'h0, 4'h0, 32'hFFB3_0002, 1'b0, 1'b1, 8'hFE, 5'h00, 1'b0, 8'h00, 1'b1, 16'hFFF7},
    // R4: read back block 3 and block 0
    '{4'd4, 4'h0, 4'h0, 32'hFFB3_0002, 1'b1, 1'b0, 8'h00, 5'h00, 1'b0, 8'h00, 1'b1, 16'hFFF7},
    '{4'd4, 4'h0, 4'h0, 32'hFFB0_0002, 1'b1, 1'b0, 8'h00, 5'h00, 1'b0, 8'h01, 1'b1, 16'hFFF7},
    // R5: unlock last block
    '{4'd5, 4'h0, 4'h0, 32'hFFBF_0002, 1'b0, 1'b1, 8'h00, 5'h00, 1'b0, 8'h00, 1'b1, 16'h7FF7},
    // R2: mismatched write then read
    '{4'd2, 4'h0, 4'h1, 32'hFFB0_0002, 1'b0, 1'b1, 8'h00, 5'h00, 1'b0, 8'h00, 1'b0, 16'h7FF7},
    '{4'd2, 4'h0, 4'h1, 32'hFFBC_0100, 1'b1, 1'b0, 8'h00, 5'h1F, 1'b0, 8'h00, 1'b0, 16'h7FF7},
    // R8: busy write and busy read
    '{4'd8, 4'h0, 4'h0, 32'hFFB0_0002, 1'b0, 1'b1, 8'h00, 5'h00, 1'b1, 8'h00, 1'b1, 16'h7FF7},
    '{4'd8, 4'h0, 4'h0, 32'hFFBC_0100, 1'b1, 1'b0, 8'h00, 5'h1F, 1'b1, 8'h00, 1'b1, 16'h7FF7},
    // R7: just past a lock register, and a write to the input register
    '{4'd7, 4'h0, 4'h0, 32'hFFB0_0003, 1'b1, 1'b0, 8'h00, 5'h00, 1'b0, 8'h00, 1'b1, 16'h7FF7},
    '{4'd7, 4'h0, 4'h0, 32'hFFBC_0100, 1'b0, 1'b1, 8'h00, 5'h00, 1'b0, 8'h00, 1'b1, 16'h7FF7},
    // R3: strap 2 moves the window down two pages
    '{4'd3, 4'h2, 4'h2, 32'hFF3C_0100, 1'b1, 1'b0, 8'h00, 5'h0A, 1'b0, 8'h0A, 1'b1, 16'h7FF7},
    // R4: strap 2 relocks block 3
    '{4'd4, 4'h2, 4'h2, 32'hFF33_0002, 1'b0, 1'b1, 8'h01, 5'h00, 1'b0, 8'h00, 1'b1, 16'h7FFF},
    // R7: strap 2 no longer answers at boot address
    '{4'd7, 4'h2, 4'h2, 32'hFFBC_0100, 1'b1, 1'b0, 8'h00, 5'h1F, 1'b0, 8'h00, 1'b1, 16'h7FFF},
    // R9: idle cycle
    '{4'd9, 4'h0, 4'h0, 32'hFFBC_0100, 1'b0, 1'b0, 8'h00, 5'h1F, 1'b0, 8'h00, 1'b0, 16'h7FFF},
    // R3: highest strap value
    '{4'd3, 4'hF, 4'hF, 32'hFBFC_0100, 1'b1, 1'b0, 8'h00, 5'h11, 1'b0, 8'h11, 1'b1, 16'h7FFF},
    // R1: strobed read with matching ID, unused address
    '{4'd1, 4'h5, 4'h5, 32'h0000_0000, 1'b1, 1'b0, 8'h00, 5'h00, 1'b0, 8'h00, 1'b1, 16'h7FFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; array_busy = 1'b0;
    addr = '0; cyc_id = '0; strap_id = '0; gpi_pins = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 lock_bits", 32'(lock_bits), 32'hFFFF);
    check("R6 rd_data", 32'(rd_data), 32'h0);
    check("R6 selected", 32'(selected), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      strap_id = TBL[i].strap; cyc_id = TBL[i].cyc; addr = TBL[i].a;
      rd_en = TBL[i].rd; wr_en = TBL[i].wr; wr_data = TBL[i].wd;
      gpi_pins = TBL[i].gpi; array_busy = TBL[i].busy;
      @(negedge clk);
      check($sformatf("R%0d rd_data vec%0d", TBL[i].req, i), 32'(rd_data), 32'(TBL[i].exp_rd));
      check($sformatf("R1 selected vec%0d", i), 32'(selected), 32'(TBL[i].exp_sel));
      check($sformatf("R%0d lock_bits vec%0d", TBL[i].req, i), 32'(lock_bits), 32'(TBL[i].exp_lock));
    end

    // R9: read data drops back to zero once the read strobe is gone
    idle_inputs();
    rd_en = 1'b1; addr = 32'hFFBC_0100; gpi_pins = 5'h07;
    @(negedge clk);
    check("R3 pass-through", 32'(rd_data), 32'h07);
    rd_en = 1'b0;
    @(negedge clk);
    check("R9 cleared after read", 32'(rd_data), 32'h0);
    check("R1 selected low when idle", 32'(selected), 32'h0);

    // R6: reset in the middle of operation relocks everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R6 relock", 32'(lock_bits), 32'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule